// File: doc/BRIEF.md
# AHB Slave to Wishbone Classic Master Bridge

This block sits on an AHB bus as a slave and forwards each word-sized single transfer to a Wishbone classic slave. AHB splits a transfer into two phases: an address phase, then a data phase in the next cycle. The bridge captures the address phase in a register. It then runs exactly one Wishbone cycle during the AHB data phase that follows.

The AHB data phase is held open with ready low until the Wishbone slave acknowledges. This lets a slow Wishbone target stretch the AHB transfer one cycle at a time. Write data is taken from the AHB bus during the data phase and is paired with the captured address and direction. Read data from the Wishbone slave is passed back in the cycle where ready goes high. Idle cycles, master busy cycles and unsupported sizes or burst kinds create no Wishbone access, and the response is always OKAY.

Top module: `ahb_wb_bridge`

## Requirements
- R1: While rst_n is low, wb_cyc and wb_stb are low, ahb_ready is high and ahb_resp is 2'b00.
- R2: A transfer is accepted on a rising edge where ahb_sel is 1, ahb_ready is 1, ahb_trans is 2'b10 (NONSEQ) or 2'b11 (SEQ), ahb_size is 3'b010 (word) and ahb_burst is 3'b000 (single). In the next cycle wb_cyc and wb_stb are both 1, wb_adr equals the accepted ahb_addr, and wb_we equals the accepted ahb_write.
- R3: During the Wishbone cycle of an accepted write, wb_dat_w carries the ahb_wdata presented in the AHB data phase.
- R4: While wb_cyc is 1 and wb_ack is 0, ahb_ready is 0.
- R5: In a cycle where wb_ack is 1, ahb_ready is 1. If no new transfer is accepted on the following edge, wb_cyc and wb_stb are 0 in the next cycle.
- R6: For a read, ahb_rdata equals wb_dat_r in the cycle where ahb_ready returns high.
- R7: With ahb_sel low, or with ahb_trans 2'b00 (IDLE) or 2'b01 (BUSY), no Wishbone cycle starts and ahb_ready stays high.
- R8: A transfer whose ahb_size is not 3'b010 or whose ahb_burst is not 3'b000 starts no Wishbone cycle.
- R9: ahb_resp is always 2'b00 (OKAY).
- R10: A transfer accepted on the edge that ends a Wishbone cycle keeps wb_cyc high without a gap. The new cycle uses the new address and the new data-phase write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Active-low reset |
| ahb_sel | input | 1 | Slave select |
| ahb_trans | input | 2 | Transfer type (IDLE/BUSY/NONSEQ/SEQ) |
| ahb_write | input | 1 | 1 for write, 0 for read |
| ahb_size | input | 3 | Transfer size; only word is accepted |
| ahb_burst | input | 3 | Burst kind; only single is accepted |
| ahb_addr | input | AW | Address-phase address |
| ahb_wdata | input | DW | Data-phase write data |
| ahb_rdata | output | DW | Read data to master |
| ahb_ready | output | 1 | Transfer done / slave ready |
| ahb_resp | output | 2 | Response, fixed OKAY |
| wb_adr | output | AW | Wishbone address |
| wb_dat_w | output | DW | Wishbone write data |
| wb_we | output | 1 | Wishbone write enable |
| wb_cyc | output | 1 | Wishbone cycle valid |
| wb_stb | output | 1 | Wishbone strobe |
| wb_dat_r | input | DW | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
Writes and reads are run against a Wishbone slave model that acknowledges after zero, one or three wait cycles. These runs show whether ready follows the acknowledge, or whether it ends the phase too early or too late. Two writes are issued back to back with no wait. This shows whether the second address phase is taken while the first cycle ends, and whether the write data goes to the right address. BUSY, IDLE, deselected and wrong-size or wrong-burst requests are each held for several cycles. They show that only a real word single transfer opens a Wishbone cycle. Reading back every written word checks the data pairing in both directions.

// File: rtl/ahb_wb_bridge.sv
module ahb_wb_bridge #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ahb_sel,
  input  logic [1:0]    ahb_trans,
  input  logic          ahb_write,
  input  logic [2:0]    ahb_size,
  input  logic [2:0]    ahb_burst,
  input  logic [AW-1:0] ahb_addr,
  input  logic [DW-1:0] ahb_wdata,
  output logic [DW-1:0] ahb_rdata,
  output logic          ahb_ready,
  output logic [1:0]    ahb_resp,
  output logic [AW-1:0] wb_adr,
  output logic [DW-1:0] wb_dat_w,
  output logic          wb_we,
  output logic          wb_cyc,
  output logic          wb_stb,
  input  logic [DW-1:0] wb_dat_r,
  input  logic          wb_ack
);

  localparam logic [2:0] SIZE_WORD    = 3'b010;
  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [1:0] RESP_OKAY    = 2'b00;

  logic          live_q;
  logic [AW-1:0] adr_q;
  logic          we_q;
  logic          take;

  assign ahb_ready = !live_q || wb_ack;

  assign take = ahb_sel && ahb_ready && ahb_trans[1]
             && (ahb_size == SIZE_WORD) && (ahb_burst == BURST_SINGLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      adr_q  <= '0;
      we_q   <= 1'b0;
    end else if (take) begin
      live_q <= 1'b1;
      adr_q  <= ahb_addr;
      we_q   <= ahb_write;
    end else if (wb_ack) begin
      live_q <= 1'b0;
    end
  end

  assign wb_cyc    = live_q;
  assign wb_stb    = live_q;
  assign wb_adr    = adr_q;
  assign wb_we     = we_q;
  assign wb_dat_w  = ahb_wdata;
  assign ahb_rdata = wb_dat_r;
  assign ahb_resp  = RESP_OKAY;

endmodule

// File: rtl/ahb_wb_bridge_chk.sv
module ahb_wb_bridge_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ahb_sel,
  input logic [1:0]    ahb_trans,
  input logic          ahb_write,
  input logic [2:0]    ahb_size,
  input logic [2:0]    ahb_burst,
  input logic [AW-1:0] ahb_addr,
  input logic          ahb_ready,
  input logic [1:0]    ahb_resp,
  input logic [AW-1:0] wb_adr,
  input logic          wb_we,
  input logic          wb_cyc,
  input logic          wb_stb,
  input logic          wb_ack
);

  logic valid_req;
  assign valid_req = ahb_sel && ahb_ready && ahb_trans[1]
                  && ahb_size == 3'b010 && ahb_burst == 3'b000;

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_req |=> (wb_cyc && wb_stb && wb_adr == $past(ahb_addr) && wb_we == $past(ahb_write)));

  p_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && !wb_ack) |-> !ahb_ready);

  p_ack_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_ack) |-> ahb_ready);

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!wb_cyc || wb_ack) && !valid_req) |=> (!wb_cyc && !wb_stb));

  p_strobe_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc == wb_stb);

  p_okay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ahb_resp == 2'b00);

endmodule

bind ahb_wb_bridge ahb_wb_bridge_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ahb_sel(ahb_sel), .ahb_trans(ahb_trans),
  .ahb_write(ahb_write), .ahb_size(ahb_size), .ahb_burst(ahb_burst),
  .ahb_addr(ahb_addr), .ahb_ready(ahb_ready), .ahb_resp(ahb_resp),
  .wb_adr(wb_adr), .wb_we(wb_we), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
  .wb_ack(wb_ack)
);

// File: tb/tb_ahb_wb_bridge.sv
`timescale 1ns/1ps
module tb_ahb_wb_bridge;
  localparam int DW = 32;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  logic ahb_sel = 0, ahb_write = 0;
  logic [1:0] ahb_trans = 2'b00;
  logic [2:0] ahb_size = 3'b010, ahb_burst = 3'b000;
  logic [AW-1:0] ahb_addr = '0;
  logic [DW-1:0] ahb_wdata = '0;
  logic [DW-1:0] ahb_rdata, wb_dat_w, wb_dat_r;
  logic ahb_ready, wb_we, wb_cyc, wb_stb, wb_ack;
  logic [1:0] ahb_resp;
  logic [AW-1:0] wb_adr;

  int checks = 0, errors = 0;
  int waits = 0;
  int cnt = 0;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] expv [16];

  always #5 clk = ~clk;

  ahb_wb_bridge #(.DW(DW), .AW(AW)) dut (.*);

  assign wb_ack   = wb_stb && (cnt == waits);
  assign wb_dat_r = mem[wb_adr[3:0]];

  always @(posedge clk) begin
    if (wb_stb && !wb_ack) cnt <= cnt + 1;
    else cnt <= 0;
    if (wb_stb && wb_ack && wb_we) mem[wb_adr[3:0]] <= wb_dat_w;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int w);
    waits = w;
    @(negedge clk);
    ahb_sel = 1; ahb_trans = 2'b10; ahb_write = wr; ahb_addr = a;
    ahb_size = 3'b010; ahb_burst = 3'b000;
    #1 chk(ahb_ready === 1'b1, "R2", ahb_ready, 1);
    @(negedge clk);
    ahb_sel = 0; ahb_trans = 2'b00; ahb_wdata = wr ? d : '0;
    #1;
    chk(wb_cyc && wb_stb, "R2", {wb_cyc, wb_stb}, 2'b11);
    chk(wb_adr == a, "R2", wb_adr, a);
    chk(wb_we == wr, "R2", wb_we, wr);
    if (wr) chk(wb_dat_w == d, "R3", wb_dat_w, d);
    for (int k = 0; k < w; k++) begin
      chk(ahb_ready == 1'b0, "R4", ahb_ready, 0);
      @(negedge clk); #1;
    end
    chk(ahb_ready == 1'b1, "R5", ahb_ready, 1);
    chk(ahb_resp == 2'b00, "R9", ahb_resp, 0);
    if (!wr) chk(ahb_rdata == expv[a[3:0]], "R6", ahb_rdata, expv[a[3:0]]);
    else expv[a[3:0]] = d;
    @(negedge clk); #1;
    chk(!wb_cyc && !wb_stb, "R5", {wb_cyc, wb_stb}, 0);
  endtask

  task automatic back_to_back();
    waits = 0;
    @(negedge clk);
    ahb_sel = 1; ahb_trans = 2'b10; ahb_write = 1; ahb_addr = 16'h0005;
    @(negedge clk);
    ahb_trans = 2'b11; ahb_addr = 16'h0006; ahb_wdata = 32'hAAAA_0005;
    #1 chk(wb_adr == 16'h0005 && ahb_ready, "R10", wb_adr, 16'h0005);
    @(negedge clk);
    ahb_sel = 0; ahb_trans = 2'b00; ahb_wdata = 32'hBBBB_0006;
    #1;
    chk(wb_cyc == 1'b1, "R10", wb_cyc, 1);
    chk(wb_adr == 16'h0006, "R10", wb_adr, 16'h0006);
    chk(wb_dat_w == 32'hBBBB_0006, "R10", wb_dat_w, 32'hBBBB_0006);
    expv[5] = 32'hAAAA_0005; expv[6] = 32'hBBBB_0006;
    @(negedge clk); #1;
    chk(!wb_cyc, "R5", wb_cyc, 0);
    xfer(0, 16'h0005, '0, 0);
    xfer(0, 16'h0006, '0, 2);
  endtask

  task automatic no_access(input logic s, input logic [1:0] t, input logic [2:0] sz,
                           input logic [2:0] bu, input string req);
    @(negedge clk);
    ahb_sel = s; ahb_trans = t; ahb_size = sz; ahb_burst = bu;
    ahb_write = 1; ahb_addr = 16'h0003;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(!wb_cyc && !wb_stb, req, wb_cyc, 0);
      chk(ahb_ready == 1'b1, req, ahb_ready, 1);
    end
    ahb_sel = 0; ahb_trans = 2'b00; ahb_size = 3'b010; ahb_burst = 3'b000;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = '0; expv[i] = '0; end
    #12;
    chk(!wb_cyc && !wb_stb, "R1", wb_cyc, 0);
    chk(ahb_ready == 1'b1, "R1", ahb_ready, 1);
    chk(ahb_resp == 2'b00, "R1", ahb_resp, 0);
    @(negedge clk); rst_n = 1;
    xfer(1, 16'h0001, 32'h1111_0001, 0);
    xfer(1, 16'h0002, 32'h2222_0002, 1);
    xfer(1, 16'h0003, 32'h3333_0003, 3);
    no_access(1, 2'b01, 3'b010, 3'b000, "R7");
    no_access(1, 2'b00, 3'b010, 3'b000, "R7");
    no_access(0, 2'b10, 3'b010, 3'b000, "R7");
    no_access(1, 2'b10, 3'b001, 3'b000, "R8");
    no_access(1, 2'b10, 3'b010, 3'b011, "R8");
    xfer(0, 16'h0003, '0, 0);
    xfer(0, 16'h0001, '0, 3);
    xfer(0, 16'h0002, '0, 1);
    back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule